// File: doc/BRIEF.md
# Serial Receiver with Sleep and Wakeup

This block turns an asynchronous serial line into received words for a microcontroller-style serial port. It looks at the line once per enable pulse of an oversampling tick that runs at sixteen times the baud rate. A frame is one start bit, then eight or nine data bits with the least significant bit first, then one stop bit. When parity is enabled, the top data position holds the parity bit and the block checks it. A finished word goes into a holding register and raises a full flag. If a frame completes while the holding register is still full, the new frame is dropped and an overrun flag is raised.

The block also watches for an idle line, meaning ones for a whole frame length. In short mode it counts every one on the line, including ones inside a frame. In long mode it starts counting only once the stop bit has ended. Software can put the receiver to sleep. While asleep it keeps following frames but raises no full or idle flag. It wakes either on an idle line or on a frame whose last data bit is one (an address mark). The frame that carries the address mark is delivered. Two interrupt requests combine the flags with their enables.

Top module: `sci_wake_rx`

## Requirements
- R1: In 8-bit format (`cfg_nine`=0) a frame carries 8 data bits and the word appears on `rx_data[7:0]` with `rx_data[8]`=0. In 9-bit format the 9 data bits appear on `rx_data[8:0]`. Bits arrive least significant first, and `rx_full` is 1 once the stop bit has been sampled.
- R2: A falling edge starts a frame only if the majority of the samples at ticks 7, 8 and 9 of the start bit is 0. A low pulse that is shorter than that is ignored: no word and no `rx_full`.
- R3: With `cfg_par_en`=1 the highest data position (bit 7 or bit 8) is the parity bit. `par_err` is 1 when the XOR of all data bits differs from `cfg_par_odd` (0 = even, 1 = odd). With `cfg_par_en`=0, `par_err` stays 0.
- R4: A frame that completes while `rx_full`=1 is discarded. `rx_data` keeps the earlier word and `overrun` becomes 1.
- R5: Short idle mode (`cfg_idle_long`=0) counts every one bit time on the line, including ones in a frame's data bits. `idle_flag` sets after 10 bit times of ones (11 in 9-bit format).
- R6: Long idle mode (`cfg_idle_long`=1) counts only ones that come after the stop bit has ended.
- R7: `idle_flag` sets at most once per run of ones. A 0 must be seen on the line before it can set again, and none can set after reset until a 0 has been seen. An `idle_clr` pulse clears it.
- R8: `sleep_set` makes `asleep`=1. While asleep, no word is delivered and no `idle_flag` is set. With `cfg_wake_addr`=0, an idle line clears `asleep` and does not set `idle_flag`.
- R9: With `cfg_wake_addr`=1, a sleeping receiver ignores frames whose last data bit is 0 and ignores idle lines. A frame whose last data bit is 1 clears `asleep` and is delivered.
- R10: `rx_irq` = `rx_ie` and (`rx_full` or `overrun`). `idle_irq` = `idle_ie` and `idle_flag`.
- R11: An `rd_ack` pulse clears `rx_full`, `overrun` and `par_err`.
- R12: After reset all flags, `asleep`, the interrupts and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| baud_tick | input | 1 | one-cycle enable at 16x the baud rate |
| rxd_in | input | 1 | serial line; resynchronised inside the block |
| cfg_nine | input | 1 | 0: 8 data bits, 1: 9 data bits |
| cfg_par_en | input | 1 | enables the parity check |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_idle_long | input | 1 | 0: short idle detect, 1: long idle detect |
| cfg_wake_addr | input | 1 | 0: wake on idle line, 1: wake on address mark |
| rx_ie | input | 1 | receive interrupt enable |
| idle_ie | input | 1 | idle interrupt enable |
| sleep_set | input | 1 | pulse that puts the receiver to sleep |
| rd_ack | input | 1 | pulse that clears full, overrun and parity error |
| idle_clr | input | 1 | pulse that clears the idle flag |
| rx_data | output | 9 | last delivered word |
| rx_full | output | 1 | a word is waiting |
| overrun | output | 1 | a frame was lost |
| par_err | output | 1 | parity error on the held word |
| idle_flag | output | 1 | idle line seen |
| asleep | output | 1 | receiver is in sleep mode |
| rx_irq | output | 1 | receive interrupt request |
| idle_irq | output | 1 | idle interrupt request |

## Verification
The assertions assume that the configuration inputs stay fixed while a frame or an idle run is in progress. They also assume that `baud_tick` is a single-cycle pulse with at least two clocks between pulses. The bench changes configuration only after the line has been idle long enough for any pending idle event to fire. It generates the tick every fourth clock and moves the line only at bit boundaries of 64 clocks. The one exception is the deliberate short start glitch.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              mark;
        logic              par_bad;
    } rx_result_t;

    // last received data bit, which is the address mark
    function automatic logic last_bit(input logic [WORD_W-1:0] w, input logic nine);
        return nine ? w[8] : w[7];
    endfunction

    // parity mismatch over every data bit, parity position included
    function automatic logic parity_bad(input logic [WORD_W-1:0] w, input logic nine,
                                        input logic odd);
        logic [WORD_W-1:0] bits;
        bits = nine ? w : {1'b0, w[7:0]};
        return (^bits) != odd;
    endfunction

endpackage

// File: rtl/rxw_frame.sv
module rxw_frame
    import rxw_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic              nine,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output logic              in_frame
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] POS_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] MAJ_A    = CW'(OVS / 2 - 2);
    localparam logic [CW-1:0] MAJ_B    = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] MAJ_C    = CW'(OVS / 2);
    localparam logic [CW-1:0] MID      = CW'(OVS / 2 - 1);

    rx_state_e         st;
    logic [CW-1:0]     tcnt;
    logic [CW-1:0]     pos;
    logic [3:0]        bidx;
    logic [WORD_W-1:0] shreg;
    logic [1:0]        maj;
    logic              maj_high;
    logic [3:0]        last_idx;

    assign pos      = (tcnt == POS_LAST) ? '0 : tcnt + 1'b1;
    assign maj_high = (maj[0] & maj[1]) | (maj[0] & rxd) | (maj[1] & rxd);
    assign last_idx = nine ? 4'd8 : 4'd7;
    assign in_frame = (st != RX_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_HUNT;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            maj   <= '0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_HUNT: begin
                        if (!rxd) begin
                            st   <= RX_START;
                            tcnt <= '0;
                        end
                    end
                    RX_START: begin
                        tcnt <= pos;
                        if (pos == MAJ_A) maj[0] <= rxd;
                        if (pos == MAJ_B) maj[1] <= rxd;
                        if (pos == MAJ_C && maj_high) begin
                            st <= RX_HUNT;
                        end else if (pos == '0) begin
                            st    <= RX_DATA;
                            bidx  <= '0;
                            shreg <= '0;
                        end
                    end
                    RX_DATA: begin
                        tcnt <= pos;
                        if (pos == MID) begin
                            if (nine) shreg <= {rxd, shreg[WORD_W-1:1]};
                            else      shreg <= {1'b0, rxd, shreg[WORD_W-2:1]};
                        end
                        if (pos == '0) begin
                            if (bidx == last_idx) st <= RX_STOP;
                            else                  bidx <= bidx + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        tcnt <= pos;
                        if (pos == MID) begin
                            done <= 1'b1;
                            word <= shreg;
                        end
                        if (pos == '0) begin
                            st   <= rxd ? RX_HUNT : RX_START;
                            tcnt <= '0;
                        end else if (pos > MID && !rxd) begin
                            st   <= RX_START;
                            tcnt <= '0;
                        end
                    end
                    default: st <= RX_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxw_idle.sv
module rxw_idle #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    input  logic nine,
    input  logic long_mode,
    input  logic in_frame,
    output logic idle_evt
);
    localparam int LW = $clog2(11 * OVS + 1);
    localparam logic [LW-1:0] LIM8 = LW'(10 * OVS - 1);
    localparam logic [LW-1:0] LIM9 = LW'(11 * OVS - 1);

    logic [LW-1:0] cnt;
    logic          armed;
    logic          cnt_en;
    logic [LW-1:0] lim;

    assign lim    = nine ? LIM9 : LIM8;
    assign cnt_en = !long_mode || !in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            idle_evt <= 1'b0;
            if (tick) begin
                if (!rxd) begin
                    cnt   <= '0;
                    armed <= 1'b1;
                end else if (cnt_en && armed) begin
                    if (cnt == lim) begin
                        idle_evt <= 1'b1;
                        armed    <= 1'b0;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R6
    long_idle_outside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_evt && $past(long_mode)) |-> !$past(in_frame));

endmodule

// File: rtl/rxw_flags.sv
module rxw_flags
    import rxw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic              nine,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              wake_addr,
    input  logic              idle_evt,
    input  logic              sleep_set,
    input  logic              rd_ack,
    input  logic              idle_clr,
    output logic [WORD_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              perr,
    output logic              idle,
    output logic              asleep
);
    rx_result_t res;
    logic       full_eff;
    logic       addr_wake;
    logic       deliver;
    logic       wake_now;

    always_comb begin
        res.word    = word;
        res.mark    = last_bit(word, nine);
        res.par_bad = par_en && parity_bad(word, nine, par_odd);
    end

    assign full_eff  = full && !rd_ack;
    assign addr_wake = wake_addr && done && res.mark;
    assign deliver   = !asleep || addr_wake;
    assign wake_now  = asleep && (addr_wake || (!wake_addr && idle_evt));

    always_ff @(posedge clk) begin
        if (rst) begin
            data   <= '0;
            full   <= 1'b0;
            ovr    <= 1'b0;
            perr   <= 1'b0;
            idle   <= 1'b0;
            asleep <= 1'b0;
        end else begin
            if (rd_ack) begin
                full <= 1'b0;
                ovr  <= 1'b0;
                perr <= 1'b0;
            end
            if (idle_clr) idle <= 1'b0;
            if (sleep_set) asleep <= 1'b1;
            if (wake_now) asleep <= 1'b0;
            if (done && deliver) begin
                if (full_eff) begin
                    ovr <= 1'b1;
                end else begin
                    data <= res.word;
                    full <= 1'b1;
                    perr <= res.par_bad;
                end
            end
            if (idle_evt && !asleep) idle <= 1'b1;
        end
    end

    // R4
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (done && full && !rd_ack) |=> $stable(data));

    // R8
    sleep_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep && !addr_wake) |=> (!$rose(full) && !$rose(idle)));

    // R11
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !done) |=> (!full && !ovr));

    // R7
    idle_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_clr && !idle_evt) |=> !idle);

endmodule

// File: rtl/sci_wake_rx.sv
module sci_wake_rx
    import rxw_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rxd_in,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_idle_long,
    input  logic              cfg_wake_addr,
    input  logic              rx_ie,
    input  logic              idle_ie,
    input  logic              sleep_set,
    input  logic              rd_ack,
    input  logic              idle_clr,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              par_err,
    output logic              idle_flag,
    output logic              asleep,
    output logic              rx_irq,
    output logic              idle_irq
);
    logic [1:0]        sync;
    logic              rxd;
    logic              done;
    logic [WORD_W-1:0] word;
    logic              in_frame;
    logic              idle_evt;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd_in};
    end
    assign rxd = sync[1];

    rxw_frame #(.OVS(OVS)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .rxd      (rxd),
        .nine     (cfg_nine),
        .done     (done),
        .word     (word),
        .in_frame (in_frame)
    );

    rxw_idle #(.OVS(OVS)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .rxd       (rxd),
        .nine      (cfg_nine),
        .long_mode (cfg_idle_long),
        .in_frame  (in_frame),
        .idle_evt  (idle_evt)
    );

    rxw_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .word      (word),
        .nine      (cfg_nine),
        .par_en    (cfg_par_en),
        .par_odd   (cfg_par_odd),
        .wake_addr (cfg_wake_addr),
        .idle_evt  (idle_evt),
        .sleep_set (sleep_set),
        .rd_ack    (rd_ack),
        .idle_clr  (idle_clr),
        .data      (rx_data),
        .full      (rx_full),
        .ovr       (overrun),
        .perr      (par_err),
        .idle      (idle_flag),
        .asleep    (asleep)
    );

    assign rx_irq   = rx_ie && (rx_full || overrun);
    assign idle_irq = idle_ie && idle_flag;

endmodule

// File: tb/tb_sci_wake_rx.sv
`timescale 1ns/1ps
module tb_sci_wake_rx;

    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rxd_in = 1'b1;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_idle_long = 1'b0, cfg_wake_addr = 1'b0;
    logic       rx_ie = 1'b0, idle_ie = 1'b0;
    logic       sleep_set = 1'b0, rd_ack = 1'b0, idle_clr = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, overrun, par_err, idle_flag, asleep, rx_irq, idle_irq;

    int checks = 0;
    int failures = 0;
    logic [1:0] tdiv = 2'd0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    sci_wake_rx dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd_in(rxd_in),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_idle_long(cfg_idle_long), .cfg_wake_addr(cfg_wake_addr),
        .rx_ie(rx_ie), .idle_ie(idle_ie), .sleep_set(sleep_set),
        .rd_ack(rd_ack), .idle_clr(idle_clr), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun), .par_err(par_err),
        .idle_flag(idle_flag), .asleep(asleep), .rx_irq(rx_irq), .idle_irq(idle_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_times(input int n);
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_word(input logic [8:0] w);
        int nb;
        nb = cfg_nine ? 9 : 8;
        @(negedge clk) rxd_in = 1'b0;
        bit_times(1);
        for (int i = 0; i < nb; i++) begin
            rxd_in = w[i];
            bit_times(1);
        end
        rxd_in = 1'b1;
        bit_times(1);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_idle_clr();
        @(negedge clk) idle_clr = 1'b1;
        @(negedge clk) idle_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle_idle();
        bit_times(12);
        pulse_idle_clr();
    endtask

    task automatic test_reset();
        check("R12 rx_full", rx_full, 0);
        check("R12 overrun", overrun, 0);
        check("R12 idle_flag", idle_flag, 0);
        check("R12 asleep", asleep, 0);
        check("R12 rx_data", rx_data, 0);
        check("R12 irqs", {rx_irq, idle_irq}, 0);
        bit_times(12);
        check("R7 no idle before first zero", idle_flag, 0);
    endtask

    task automatic test_formats();
        send_word(9'h0A5);
        check("R1 8-bit data", rx_data, 9'h0A5);
        check("R1 full", rx_full, 1);
        pulse_ack();
        check("R11 ack clears full", rx_full, 0);
        cfg_nine = 1'b1;
        send_word(9'h1C3);
        check("R1 9-bit data", rx_data, 9'h1C3);
        pulse_ack();
        cfg_nine = 1'b0;
    endtask

    task automatic test_glitch();
        @(negedge clk) rxd_in = 1'b0;
        repeat (12) @(negedge clk);
        rxd_in = 1'b1;
        bit_times(12);
        check("R2 short low ignored", rx_full, 0);
        send_word(9'h03C);
        check("R2 next frame ok", rx_data, 9'h03C);
        pulse_ack();
    endtask

    task automatic test_parity();
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        send_word(9'h003);
        check("R3 even good", par_err, 0);
        pulse_ack();
        send_word(9'h007);
        check("R3 even bad", par_err, 1);
        pulse_ack();
        check("R11 ack clears par_err", par_err, 0);
        cfg_par_odd = 1'b1;
        send_word(9'h007);
        check("R3 odd good", par_err, 0);
        pulse_ack();
        cfg_par_en = 1'b0;
        send_word(9'h007);
        check("R3 disabled", par_err, 0);
        pulse_ack();
        cfg_par_odd = 1'b0;
    endtask

    task automatic test_overrun();
        send_word(9'h011);
        send_word(9'h022);
        check("R4 overrun", overrun, 1);
        check("R4 data kept", rx_data, 9'h011);
        check("R10 rx_irq masked", rx_irq, 0);
        @(negedge clk) rx_ie = 1'b1;
        @(negedge clk);
        check("R10 rx_irq on", rx_irq, 1);
        pulse_ack();
        check("R11 ack clears overrun", {rx_full, overrun}, 0);
        check("R10 rx_irq off", rx_irq, 0);
        rx_ie = 1'b0;
    endtask

    task automatic test_idle_short();
        settle_idle();
        cfg_idle_long = 1'b0;
        send_word(9'h0F0);
        pulse_ack();
        bit_times(3);
        check("R5 short not yet", idle_flag, 0);
        bit_times(4);
        check("R5 short set", idle_flag, 1);
        check("R10 idle_irq masked", idle_irq, 0);
        @(negedge clk) idle_ie = 1'b1;
        @(negedge clk);
        check("R10 idle_irq on", idle_irq, 1);
        idle_ie = 1'b0;
        pulse_idle_clr();
        check("R7 idle cleared", idle_flag, 0);
        bit_times(12);
        check("R7 once per run", idle_flag, 0);
    endtask

    task automatic test_idle_long();
        cfg_idle_long = 1'b1;
        send_word(9'h0F0);
        pulse_ack();
        bit_times(7);
        check("R6 long not yet", idle_flag, 0);
        bit_times(5);
        check("R6 long set", idle_flag, 1);
        pulse_idle_clr();
        cfg_idle_long = 1'b0;
    endtask

    task automatic test_wake_idle();
        settle_idle();
        cfg_wake_addr = 1'b0;
        @(negedge clk) sleep_set = 1'b1;
        @(negedge clk) sleep_set = 1'b0;
        check("R8 asleep", asleep, 1);
        send_word(9'h055);
        check("R8 no delivery asleep", rx_full, 0);
        check("R8 still asleep", asleep, 1);
        bit_times(12);
        check("R8 idle wakes", asleep, 0);
        check("R8 no idle flag on wake", idle_flag, 0);
        send_word(9'h066);
        check("R8 delivery after wake", rx_data, 9'h066);
        pulse_ack();
    endtask

    task automatic test_wake_addr();
        settle_idle();
        cfg_wake_addr = 1'b1;
        @(negedge clk) sleep_set = 1'b1;
        @(negedge clk) sleep_set = 1'b0;
        send_word(9'h012);
        check("R9 non-mark ignored", rx_full, 0);
        bit_times(12);
        check("R9 idle does not wake", asleep, 1);
        check("R9 no idle flag asleep", idle_flag, 0);
        send_word(9'h081);
        check("R9 mark wakes", asleep, 0);
        check("R9 mark delivered", {rx_full, rx_data}, {1'b1, 9'h081});
        pulse_ack();
        cfg_wake_addr = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        test_reset();
        test_formats();
        test_glitch();
        test_parity();
        test_overrun();
        test_idle_short();
        test_idle_long();
        test_wake_idle();
        test_wake_addr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule